// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and a calendar as packed BCD fields: seconds, minutes, hours in 24-hour form, a day-of-week code, day of month, month and a four-digit year. Each accepted one-second tick moves the time forward by one second. Carries ripple from seconds up to the year, following month lengths and leap years. The year runs up to 9999 and then wraps to 0000.

A synchronous load strobe replaces every field in one cycle with a full set of supplied values. An enable input gates the tick, so a host can freeze the count while it reads or rewrites the time. Values that are not legal BCD are accepted as loaded. Such a nibble steps up to 0xF and rolls over to 0x0, and counting then carries on from there. A field whose value is above its legal maximum keeps counting and does not carry until the count reaches that maximum exactly.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00, day of week 01, date 01, month 01 and year RESET_YEAR (default 0x2000).
- R2: When load_i is high at a clock edge, all seven fields take the supplied values together at that edge. This holds whatever the states of en_i and tick_i, and load wins over a simultaneous tick.
- R3: Time advances by exactly one second at an edge where en_i and tick_i are both high and load_i is low. At every other edge without a load, all fields hold their values.
- R4: Seconds and minutes count 0x00 to 0x59, and each carries into the next field when it goes from 0x59 to 0x00. Hours count 0x00 to 0x23, and a step from 0x23 to 0x00 marks a new day.
- R5: On each new day, the day of week goes up by one and wraps from 0x07 to 0x01, whatever the date.
- R6: On a new day the date wraps to 0x01 and the month advances only when the date equals the month length. Months 0x04, 0x06, 0x09 and 0x11 have 0x30 days. Month 0x02 has 0x28 days, or 0x29 in a leap year. Every other month code has 0x31 days.
- R7: A year is a leap year when it is divisible by 4, unless it is divisible by 100 and not by 400. For example, 2024 and 2000 are leap years, while 2100 and 1900 are not.
- R8: The month wraps from 0x12 to 0x01 and carries into the year. The year counts in four-digit BCD across the century boundary, and it wraps from 0x9999 to 0x0000.
- R9: A loaded nibble in the range 0xA to 0xF goes up by one on each step in which it would change, and rolls from 0xF to 0x0 without carrying into the nibble above. After that, normal BCD counting resumes. A low nibble of 9 sets itself to 0 and advances the nibble above it.
- R10: A field carries into the next field only when it equals its legal maximum exactly. A field loaded above its maximum (for example, hour 0x24) counts on without carrying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Tick enable |
| tick_i | input | 1 | One-second tick, one clock wide |
| load_i | input | 1 | Load all fields from the ld_* inputs |
| ld_sec_i | input | 8 | Seconds to load, BCD |
| ld_min_i | input | 8 | Minutes to load, BCD |
| ld_hour_i | input | 8 | Hours to load, BCD 24-hour |
| ld_dow_i | input | 8 | Day of week to load |
| ld_date_i | input | 8 | Day of month to load, BCD |
| ld_month_i | input | 8 | Month to load, BCD |
| ld_year_i | input | 16 | Year to load, four BCD digits |
| sec_o | output | 8 | Current seconds |
| min_o | output | 8 | Current minutes |
| hour_o | output | 8 | Current hours |
| dow_o | output | 8 | Current day of week |
| date_o | output | 8 | Current day of month |
| month_o | output | 8 | Current month |
| year_o | output | 16 | Current year |

## Verification
The bench goes after the points where the whole chain carries at once: the last second of 9999, February 28 in the leap years 2000 and 2024 and in the non-leap year 2100, and the last day of a 30-day month. A design with a wrong leap rule would skip or add February 29. A design with a broken chain would wrap the year to 1000 or leave the month unchanged. Loaded seconds of 0x5A and hours of 0x24 test the non-BCD rule and the exact-maximum rule. A design that got these wrong would carry into the minutes or the date too early, or would clamp the field. Random loads near the carry boundaries, mixed with gated ticks, also check that the count holds when en_i is low and that a load beats a tick.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter logic [15:0] RESET_YEAR = 16'h2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_i,
  input  logic        tick_i,
  input  logic        load_i,
  input  logic [7:0]  ld_sec_i,
  input  logic [7:0]  ld_min_i,
  input  logic [7:0]  ld_hour_i,
  input  logic [7:0]  ld_dow_i,
  input  logic [7:0]  ld_date_i,
  input  logic [7:0]  ld_month_i,
  input  logic [15:0] ld_year_i,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  dow_o,
  output logic [7:0]  date_o,
  output logic [7:0]  month_o,
  output logic [15:0] year_o
);

  localparam int YEAR_DIGITS = 4;

  function automatic logic [3:0] step_nib(input logic [3:0] n);
    return (n == 4'h9) ? 4'h0 : n + 4'h1;
  endfunction

  function automatic logic [7:0] bump8(input logic [7:0] v);
    logic [7:0] r;
    r[3:0] = step_nib(v[3:0]);
    r[7:4] = (v[3:0] == 4'h9) ? step_nib(v[7:4]) : v[7:4];
    return r;
  endfunction

  function automatic logic mult4(input logic [7:0] b);
    if (b[4]) return (b[3:0] == 4'h2) || (b[3:0] == 4'h6);
    else      return (b[3:0] == 4'h0) || (b[3:0] == 4'h4) || (b[3:0] == 4'h8);
  endfunction

  logic [7:0]  sec_q, min_q, hour_q, dow_q, date_q, month_q;
  logic [15:0] year_q, year_inc;
  logic        tk, leap;
  logic [7:0]  month_len;
  logic        c_sec, c_min, c_hr, c_date, c_mon;
  logic [YEAR_DIGITS:0] ychain;

  assign tk   = en_i & tick_i & ~load_i;
  assign leap = (year_q[7:0] == 8'h00) ? mult4(year_q[15:8]) : mult4(year_q[7:0]);

  always_comb begin
    case (month_q)
      8'h02:                      month_len = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_len = 8'h30;
      default:                    month_len = 8'h31;
    endcase
  end

  assign c_sec  = tk && (sec_q == 8'h59);
  assign c_min  = c_sec && (min_q == 8'h59);
  assign c_hr   = c_min && (hour_q == 8'h23);
  assign c_date = c_hr && (date_q == month_len);
  assign c_mon  = c_date && (month_q == 8'h12);

  assign ychain[0] = 1'b1;
  for (genvar g = 0; g < YEAR_DIGITS; g++) begin : g_year
    assign year_inc[4*g +: 4] = ychain[g] ? step_nib(year_q[4*g +: 4]) : year_q[4*g +: 4];
    assign ychain[g+1]        = ychain[g] && (year_q[4*g +: 4] == 4'h9);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hour_q  <= 8'h00;
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= RESET_YEAR;
    end else if (load_i) begin
      sec_q   <= ld_sec_i;
      min_q   <= ld_min_i;
      hour_q  <= ld_hour_i;
      dow_q   <= ld_dow_i;
      date_q  <= ld_date_i;
      month_q <= ld_month_i;
      year_q  <= ld_year_i;
    end else if (tk) begin
      sec_q <= c_sec ? 8'h00 : bump8(sec_q);
      if (c_sec) min_q <= c_min ? 8'h00 : bump8(min_q);
      if (c_min) hour_q <= c_hr ? 8'h00 : bump8(hour_q);
      if (c_hr) begin
        dow_q  <= (dow_q == 8'h07) ? 8'h01 : bump8(dow_q);
        date_q <= c_date ? 8'h01 : bump8(date_q);
      end
      if (c_date) month_q <= c_mon ? 8'h01 : bump8(month_q);
      if (c_mon) year_q <= year_inc;
    end
  end

  assign sec_o   = sec_q;
  assign min_o   = min_q;
  assign hour_o  = hour_q;
  assign dow_o   = dow_q;
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> ({year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o} ==
                $past({ld_year_i, ld_month_i, ld_date_i, ld_dow_i, ld_hour_i, ld_min_i, ld_sec_i})));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(en_i && tick_i)) |=>
      $stable({year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o}));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && en_i && tick_i && sec_o == 8'h59) |=> (sec_o == 8'h00));

  assert_min_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && en_i && tick_i && sec_o != 8'h59) |=> $stable({min_o, hour_o, date_o}));

  assert_dow_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && en_i && tick_i && {hour_o, min_o, sec_o} == 24'h235959 && dow_o == 8'h07)
      |=> (dow_o == 8'h01));

  assert_year_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && en_i && tick_i && {year_o, month_o, date_o, hour_o, min_o, sec_o} ==
      64'h9999_12_31_235959) |=> (year_o == 16'h0000 && month_o == 8'h01 && date_o == 8'h01));

endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, tick_i = 1'b0, load_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_dow_i = '0;
  logic [7:0] ld_date_i = '0, ld_month_i = '0;
  logic [15:0] ld_year_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o;
  logic [15:0] year_o;

  int checks = 0, fails = 0;
  logic [63:0] exp_st;

  always #10 clk = ~clk;

  bcd_calendar u0 (.*);

  // state layout: {year16, month8, date8, dow8, hour8, min8, sec8}
  function automatic logic [63:0] pk(input int y, mo, d, w, h, mi, s);
    return {to_bcd4(y), to_bcd2(mo), to_bcd2(d), to_bcd2(w), to_bcd2(h), to_bcd2(mi), to_bcd2(s)};
  endfunction

  function automatic logic [7:0] to_bcd2(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] to_bcd4(input int v);
    return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] inc8(input logic [7:0] v);
    logic [3:0] lo = v[3:0], hi = v[7:4];
    if (lo == 4'd9) begin
      lo = 4'd0;
      hi = (hi == 4'd9) ? 4'd0 : hi + 4'd1;
    end else lo = lo + 4'd1;
    return {hi, lo};
  endfunction

  function automatic logic [63:0] model_tick(input logic [63:0] st);
    logic [15:0] y = st[63:48];
    logic [7:0] mo = st[47:40], d = st[39:32], w = st[31:24], h = st[23:16], mi = st[15:8], s = st[7:0];
    int yv, mv, len;
    bit carry;
    yv = y[15:12]*1000 + y[11:8]*100 + y[7:4]*10 + y[3:0];
    mv = mo[7:4]*10 + mo[3:0];
    if (mo[3:0] > 9 || mo[7:4] > 9) len = 31;
    else if (mv == 2) len = ((yv % 4 == 0 && yv % 100 != 0) || yv % 400 == 0) ? 29 : 28;
    else if (mv == 4 || mv == 6 || mv == 9 || mv == 11) len = 30;
    else len = 31;
    if (s != 8'h59) return {y, mo, d, w, h, mi, inc8(s)};
    s = 8'h00;
    if (mi != 8'h59) return {y, mo, d, w, h, inc8(mi), s};
    mi = 8'h00;
    if (h != 8'h23) return {y, mo, d, w, inc8(h), mi, s};
    h = 8'h00;
    w = (w == 8'h07) ? 8'h01 : inc8(w);
    if (d != to_bcd2(len)) return {y, mo, inc8(d), w, h, mi, s};
    d = 8'h01;
    if (mo != 8'h12) return {y, inc8(mo), d, w, h, mi, s};
    mo = 8'h01;
    carry = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (carry) begin
        if (y[4*i +: 4] == 4'd9) y[4*i +: 4] = 4'd0;
        else begin y[4*i +: 4] = y[4*i +: 4] + 4'd1; carry = 1'b0; end
      end
    end
    return {y, mo, d, w, h, mi, s};
  endfunction

  function automatic logic [63:0] dut_st();
    return {year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // called just after a negedge; returns just after the following negedge
  task automatic cyc(input bit ld, input bit en, input bit tk, input logic [63:0] lv, input string tag);
    load_i = ld; en_i = en; tick_i = tk;
    {ld_year_i, ld_month_i, ld_date_i, ld_dow_i, ld_hour_i, ld_min_i, ld_sec_i} = lv;
    if (ld) exp_st = lv;
    else if (en && tk) exp_st = model_tick(exp_st);
    @(posedge clk);
    @(negedge clk);
    check(tag, dut_st(), exp_st);
  endtask

  task automatic load(input logic [63:0] lv, input string tag);
    cyc(1'b1, 1'b0, 1'b0, lv, tag);
  endtask

  task automatic tick(input string tag);
    cyc(1'b0, 1'b1, 1'b1, '0, tag);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_st = 64'h2000_01_01_01_000000;
    check("R1 reset", dut_st(), exp_st);

    // R2: load with enable low and tick high, then load beats tick
    cyc(1'b1, 1'b0, 1'b1, pk(2024, 2, 28, 3, 23, 59, 59), "R2 load");
    cyc(1'b1, 1'b1, 1'b1, pk(2024, 2, 28, 3, 23, 59, 58), "R2 load wins");
    // R3: gated ticks hold
    cyc(1'b0, 1'b0, 1'b1, '0, "R3 hold en low");
    cyc(1'b0, 1'b1, 1'b0, '0, "R3 hold no tick");
    tick("R4 sec step");
    tick("R7 leap 2024");
    check("R7 feb29 2024", dut_st(), 64'h2024_02_29_04_000000);

    load(pk(2000, 2, 28, 7, 23, 59, 59), "R2");
    tick("R5 dow wrap");
    check("R5 dow 7->1 and R7 leap 2000", dut_st(), 64'h2000_02_29_01_000000);

    load(pk(2100, 2, 28, 2, 23, 59, 59), "R2");
    tick("R7 2100 not leap");
    check("R7 2100 to march", dut_st(), 64'h2100_03_01_03_000000);

    load(pk(1900, 2, 28, 2, 23, 59, 59), "R2");
    tick("R7 1900 not leap");
    check("R7 1900 to march", dut_st(), 64'h1900_03_01_03_000000);

    load(pk(2023, 4, 30, 5, 23, 59, 59), "R2");
    tick("R6 april end");
    check("R6 april 30 to may 1", dut_st(), 64'h2023_05_01_06_000000);

    load(pk(1999, 12, 31, 6, 23, 59, 59), "R2");
    tick("R8 century");
    check("R8 1999 to 2000", dut_st(), 64'h2000_01_01_07_000000);

    load(pk(9999, 12, 31, 1, 23, 59, 59), "R2");
    tick("R8 year wrap");
    check("R8 9999 to 0000", dut_st(), 64'h0000_01_01_02_000000);

    // R9: invalid seconds low nibble
    load(64'h2011_06_15_03_10205A, "R2");
    for (int i = 0; i < 6; i++) tick("R9 nibble count");
    check("R9 5A rolls to 50 no carry", dut_st(), 64'h2011_06_15_03_102050);
    for (int i = 0; i < 10; i++) tick("R9 resume");
    check("R9 normal after roll", dut_st(), 64'h2011_06_15_03_102100);

    // R10: hour above maximum counts on without day carry
    load(64'h2011_06_15_03_245959, "R2");
    tick("R10 hour 24");
    check("R10 hour 24 to 25 no date carry", dut_st(), 64'h2011_06_15_03_250000);

    // random phase near carry boundaries
    for (int n = 0; n < 400; n++) begin
      int y, mo, d, h, mi, s, w;
      y  = ($urandom % 4 == 0) ? 9999 : ($urandom % 3 == 0 ? 100 * ($urandom % 100) : $urandom % 10000);
      mo = 1 + $urandom % 12;
      d  = 27 + $urandom % 2;
      if (mo != 2) d = 28 + $urandom % 3;
      w  = 1 + $urandom % 7;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      s  = 55 + $urandom % 5;
      load(pk(y, mo, d, w, h, mi, s), "R2 random load");
      for (int k = 0; k < 12; k++)
        cyc(($urandom % 16) == 0, ($urandom % 4) != 0, ($urandom % 3) != 0,
            pk(y, mo, d, w, h, mi, s), "R3 random run");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule